// File: doc/BRIEF.md
# Global-History Correlating Branch Direction Predictor

This block predicts whether a conditional branch will be taken. A short shift register keeps the outcomes of the most recently resolved branches, whichever branches they were. Its value picks one of several banks of 2-bit saturating counters. Low bits of the branch address then pick the counter inside that bank. The counter's upper bit is the prediction.

A fetch stage presents a branch address on the lookup port. It receives the predicted direction together with the history value that was used to form it. The fetch stage carries that history alongside the branch. When the branch resolves, the address, the real outcome and the carried history come back on the resolve port. The same counter is then trained, even if the live history has moved on since the lookup. A flush input reloads the history register with a supplied value, so the front end can restore it after a misspeculated path. With the history length set to 0 the block becomes a plain address-indexed table of 2-bit counters.

Top module: `corr_bp`

## Requirements
- R1: After reset the history register is all zeros and every counter holds 01 (weakly not taken), so every lookup predicts not taken and returns history 0.
- R2: `lkp_taken_o` is bit 1 of the counter at index {history, pc[PC_LSB+IDX_W-1:PC_LSB]}. The history forms the upper index bits and selects the bank.
- R3: A resolve with outcome taken increments the addressed counter, saturating at 11.
- R4: A resolve with outcome not taken decrements the addressed counter, saturating at 00.
- R5: A counter at 11 still predicts taken after one not-taken resolve, and predicts not taken after a second one.
- R6: A resolve without flush shifts the outcome into history bit 0 (1 = taken), and the oldest bit is dropped.
- R7: The counter written on resolve is addressed by `res_hist_i` and `res_pc_i`, not by the live history.
- R8: A flush loads `flush_hist_i` into the history register. In a cycle with both flush and resolve, the flush value wins for the history, and the counter update still takes place.
- R9: A lookup in the same cycle as a resolve to the same counter sees the value from before the update. The new value is visible from the next cycle.
- R10: Address bits outside pc[PC_LSB+IDX_W-1:PC_LSB] do not affect which counter is used.
- R11: `lkp_hist_o` always equals the current history register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_pc_i | input | PC_W | Address of the branch being predicted |
| lkp_taken_o | output | 1 | Predicted direction, 1 = taken |
| lkp_hist_o | output | max(HIST_W,1) | History used for this prediction |
| res_valid_i | input | 1 | A branch resolves this cycle |
| res_pc_i | input | PC_W | Address of the resolving branch |
| res_taken_i | input | 1 | Actual outcome, 1 = taken |
| res_hist_i | input | max(HIST_W,1) | History captured at that branch's lookup |
| flush_i | input | 1 | Restore the history register |
| flush_hist_i | input | max(HIST_W,1) | History value to restore |

## Verification
Two pairs of functions can fall in the same cycle. A flush can coincide with a resolve. A lookup can coincide with a resolve that trains the very counter being read. The bench drives flush and resolve together on purpose. It expects the history to take the flush value while the counter still trains. It also issues a lookup of the exact entry under training and expects the pre-update prediction that cycle. A behavioural model, compared every cycle, judges both cases and a long random stream where these overlaps occur freely.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef logic [1:0] ctr_t;
  localparam ctr_t CTR_RESET = 2'b01;

  function automatic ctr_t ctr_next(ctr_t c, logic taken);
    if (taken) return (c == 2'b11) ? c : c + 2'd1;
    else       return (c == 2'b00) ? c : c - 2'd1;
  endfunction
endpackage

// File: rtl/bp_hist_reg.sv
module bp_hist_reg #(
  parameter int HIST_W = 3,
  localparam int HW = (HIST_W > 0) ? HIST_W : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          shift_i,
  input  logic          bit_i,
  input  logic          load_i,
  input  logic [HW-1:0] load_val_i,
  output logic [HW-1:0] hist_o
);
  generate
    if (HIST_W == 0) begin : g_none
      logic unused_in;
      assign unused_in = ^{shift_i, bit_i, load_i, load_val_i, clk_i, rst_ni};
      assign hist_o = '0;
    end else begin : g_hist
      logic [HW-1:0] hist_q, hist_d;
      always_comb begin
        hist_d = hist_q;
        if (load_i)       hist_d = load_val_i;
        else if (shift_i) hist_d = HW'({hist_q, bit_i});
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hist_q <= '0;
        else         hist_q <= hist_d;
      end
      assign hist_o = hist_q;
    end
  endgenerate
endmodule

// File: rtl/bp_index.sv
module bp_index #(
  parameter int HIST_W = 3,
  parameter int IDX_W  = 8,
  parameter int PC_W   = 32,
  parameter int PC_LSB = 2,
  localparam int HW = (HIST_W > 0) ? HIST_W : 1,
  localparam int AW = HIST_W + IDX_W
) (
  input  logic [HW-1:0]   hist_i,
  input  logic [PC_W-1:0] pc_i,
  output logic [AW-1:0]   idx_o
);
  logic [IDX_W-1:0] pc_bits;
  logic unused_pc;
  assign pc_bits   = pc_i[PC_LSB +: IDX_W];
  assign unused_pc = ^pc_i;

  generate
    if (HIST_W > 0) begin : g_corr
      assign idx_o = {hist_i, pc_bits};
    end else begin : g_flat
      logic unused_hist;
      assign unused_hist = ^hist_i;
      assign idx_o = pc_bits;
    end
  endgenerate
endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
  import bp_pkg::*;
#(
  parameter int AW = 11,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] rd_idx_i,
  output ctr_t          rd_ctr_o,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_idx_i,
  input  logic          wr_taken_i
);
  ctr_t ctr_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_RESET;
    end else if (wr_en_i) begin
      ctr_q[wr_idx_i] <= ctr_next(ctr_q[wr_idx_i], wr_taken_i);
    end
  end

  assign rd_ctr_o = ctr_q[rd_idx_i];
endmodule

// File: rtl/corr_bp.sv
module corr_bp
  import bp_pkg::*;
#(
  parameter int HIST_W = 3,
  parameter int IDX_W  = 8,
  parameter int PC_W   = 32,
  parameter int PC_LSB = 2,
  localparam int HW = (HIST_W > 0) ? HIST_W : 1,
  localparam int AW = HIST_W + IDX_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] lkp_pc_i,
  output logic            lkp_taken_o,
  output logic [HW-1:0]   lkp_hist_o,
  input  logic            res_valid_i,
  input  logic [PC_W-1:0] res_pc_i,
  input  logic            res_taken_i,
  input  logic [HW-1:0]   res_hist_i,
  input  logic            flush_i,
  input  logic [HW-1:0]   flush_hist_i
);
  logic [HW-1:0] hist;
  logic [AW-1:0] rd_idx, wr_idx;
  ctr_t          rd_ctr;

  bp_hist_reg #(.HIST_W(HIST_W)) u_hist (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_i    (res_valid_i),
    .bit_i      (res_taken_i),
    .load_i     (flush_i),
    .load_val_i (flush_hist_i),
    .hist_o     (hist)
  );

  bp_index #(.HIST_W(HIST_W), .IDX_W(IDX_W), .PC_W(PC_W), .PC_LSB(PC_LSB)) u_lkp_idx (
    .hist_i (hist),
    .pc_i   (lkp_pc_i),
    .idx_o  (rd_idx)
  );

  // resolve path indexes with the history captured at lookup time
  bp_index #(.HIST_W(HIST_W), .IDX_W(IDX_W), .PC_W(PC_W), .PC_LSB(PC_LSB)) u_res_idx (
    .hist_i (res_hist_i),
    .pc_i   (res_pc_i),
    .idx_o  (wr_idx)
  );

  bp_ctr_table #(.AW(AW)) u_tbl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (rd_idx),
    .rd_ctr_o   (rd_ctr),
    .wr_en_i    (res_valid_i),
    .wr_idx_i   (wr_idx),
    .wr_taken_i (res_taken_i)
  );

  assign lkp_taken_o = rd_ctr[1];
  assign lkp_hist_o  = hist;
endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
  parameter int HIST_W = 3,
  parameter int PC_W   = 32,
  localparam int HW = (HIST_W > 0) ? HIST_W : 1
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [PC_W-1:0] lkp_pc_i,
  input logic            lkp_taken_o,
  input logic [HW-1:0]   lkp_hist_o,
  input logic            res_valid_i,
  input logic            res_taken_i,
  input logic            flush_i,
  input logic [HW-1:0]   flush_hist_i
);
  generate
    if (HIST_W > 0) begin : g_hist_chk
      a_r6_shift_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
        res_valid_i && !flush_i |=> lkp_hist_o == HW'({$past(lkp_hist_o), $past(res_taken_i)}));

      a_r8_flush_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> lkp_hist_o == $past(flush_hist_i));
    end
  endgenerate

  a_r11_hist_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_i && !flush_i |=> $stable(lkp_hist_o));

  // no training and no history move: same address gives same answer
  a_r2_pred_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!res_valid_i && !flush_i) && $stable(lkp_pc_i) |-> $stable(lkp_taken_o));
endmodule

bind corr_bp bp_checker #(.HIST_W(HIST_W), .PC_W(PC_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .lkp_pc_i     (lkp_pc_i),
  .lkp_taken_o  (lkp_taken_o),
  .lkp_hist_o   (lkp_hist_o),
  .res_valid_i  (res_valid_i),
  .res_taken_i  (res_taken_i),
  .flush_i      (flush_i),
  .flush_hist_i (flush_hist_i)
);

// File: tb/tb_corr_bp.sv
`timescale 1ns/1ps
module tb_corr_bp;
  localparam int HIST_W = 3;
  localparam int IDX_W  = 8;
  localparam int PC_W   = 32;
  localparam int PC_LSB = 2;
  localparam int NENT   = (1 << HIST_W) << IDX_W;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [PC_W-1:0] lkp_pc = '0;
  logic            lkp_taken;
  logic [HIST_W-1:0] lkp_hist;
  logic            res_valid = 1'b0;
  logic [PC_W-1:0] res_pc = '0;
  logic            res_taken = 1'b0;
  logic [HIST_W-1:0] res_hist = '0;
  logic            flush = 1'b0;
  logic [HIST_W-1:0] flush_hist = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int ref_ctr [NENT];
  int ref_hist;

  always #2 clk = ~clk;

  corr_bp #(.HIST_W(HIST_W), .IDX_W(IDX_W), .PC_W(PC_W), .PC_LSB(PC_LSB)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .lkp_pc_i(lkp_pc), .lkp_taken_o(lkp_taken), .lkp_hist_o(lkp_hist),
    .res_valid_i(res_valid), .res_pc_i(res_pc), .res_taken_i(res_taken), .res_hist_i(res_hist),
    .flush_i(flush), .flush_hist_i(flush_hist)
  );

  function automatic int ix(int h, logic [PC_W-1:0] pc);
    return h * (1 << IDX_W) + int'((pc >> PC_LSB) & ((1 << IDX_W) - 1));
  endfunction

  task automatic step(input logic [PC_W-1:0] pc, input bit rv, input logic [PC_W-1:0] rpc,
                      input bit rt, input int rh, input bit fl, input int fh, input string tag);
    bit exp_pred;
    int k;
    lkp_pc = pc; res_valid = rv; res_pc = rpc; res_taken = rt;
    res_hist = HIST_W'(rh); flush = fl; flush_hist = HIST_W'(fh);
    #1;
    exp_pred = ref_ctr[ix(ref_hist, pc)] >= 2;
    checks++;
    if (lkp_taken !== exp_pred) begin
      errors++;
      $display("FAIL %s prediction pc=%h actual=%b expected=%b", tag, pc, lkp_taken, exp_pred);
    end
    checks++;
    if (int'(lkp_hist) != ref_hist) begin
      errors++;
      $display("FAIL R11/%s history actual=%0d expected=%0d", tag, lkp_hist, ref_hist);
    end
    @(posedge clk);
    if (rv) begin
      k = ix(rh, rpc);
      if (rt) ref_ctr[k] = (ref_ctr[k] == 3) ? 3 : ref_ctr[k] + 1;
      else    ref_ctr[k] = (ref_ctr[k] == 0) ? 0 : ref_ctr[k] - 1;
    end
    if (fl)      ref_hist = fh;
    else if (rv) ref_hist = ((ref_hist << 1) | int'(rt)) & ((1 << HIST_W) - 1);
    @(negedge clk);
  endtask

  task automatic look(input logic [PC_W-1:0] pc, input string tag);
    step(pc, 0, '0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    localparam logic [PC_W-1:0] PA = 32'h0000_0100;
    localparam logic [PC_W-1:0] PB = 32'h0000_0104;
    for (int i = 0; i < NENT; i++) ref_ctr[i] = 1;
    ref_hist = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    look(PA, "R1"); look(PB, "R1"); look(32'hFFFF_FFFC, "R1");

    // R3 with R8: train PA at history 0, flush pins history to 0
    repeat (4) step(PA, 1, PA, 1, 0, 1, 0, "R3");
    look(PA, "R3");

    // R5: one not-taken from strong keeps taken, second flips
    step(PA, 1, PA, 0, 0, 1, 0, "R5");
    look(PA, "R5");
    step(PA, 1, PA, 0, 0, 1, 0, "R5");
    look(PA, "R5");

    // R4: saturate down
    repeat (4) step(PA, 1, PA, 0, 0, 1, 0, "R4");
    look(PA, "R4");

    // R6: outcomes shift into history
    step(PB, 1, PB, 1, 5, 0, 0, "R6");
    step(PB, 1, PB, 1, 5, 0, 0, "R6");
    step(PB, 1, PB, 0, 5, 0, 0, "R6");
    look(PB, "R6");

    // R7: training uses carried history, not live one
    step(PB, 1, PB, 1, 2, 0, 0, "R7");
    step(PB, 1, PB, 1, 2, 0, 0, "R7");
    step(PB, 0, '0, 0, 0, 1, 2, "R7");
    look(PB, "R7");
    step(PB, 0, '0, 0, 0, 1, 6, "R7");
    look(PB, "R7");

    // R9: lookup coincides with update of same entry
    step(PA, 0, '0, 0, 0, 1, 0, "R9");
    step(PA, 1, PA, 1, 0, 0, 0, "R9");
    step(PA, 0, '0, 0, 0, 1, 0, "R9");
    step(PA, 1, PA, 1, 0, 1, 0, "R9");
    look(PA, "R9");

    // R10: aliasing address
    look(32'h0010_0101, "R10");
    look(32'h8000_0103, "R10");

    // R8: flush alone, and flush together with resolve
    step(PA, 0, '0, 0, 0, 1, 6, "R8");
    look(PA, "R8");
    step(PA, 1, PB, 1, 6, 1, 3, "R8");
    look(PB, "R8");

    // R2: random stream
    for (int n = 0; n < 3000; n++) begin
      logic [PC_W-1:0] rp;
      logic [PC_W-1:0] lp;
      lp = {$urandom} & 32'h0000_003C;
      rp = {$urandom} & 32'h0000_003C;
      step(lp, ($urandom % 4) != 0, rp, $urandom % 2, $urandom % 8,
           ($urandom % 8) == 0, $urandom % 8, "R2");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule